// File: doc/BRIEF.md
# Wake-on-Access Hibernate Bus Bridge

This bridge sits between a processor-side request bus (valid/ready) and the register bus of a peripheral domain that can be put into hibernate. While the domain is awake, every request goes straight through in the cycle it is presented. When the domain is asleep, any request, read or write, wakes it. The bridge raises a wake request, holds the access stalled until the domain acknowledges, and then lets the access complete. If no acknowledge arrives within a bounded number of cycles, the access ends with an error response and the domain stays asleep.

The bridge holds the domain's two-bit mode register. Writing the hibernate code puts the domain to sleep. After any wake-up the register keeps reporting hibernate until software writes the active code back. A settle timer starts on every exit from hibernate. While it runs, or while the domain sleeps, requests to start a conversion are refused and a sticky flag records the early attempt. The window length is derived from the clock frequency and the required settle time as a rounded-up cycle count.

Top module: `hib_wake_bridge`

## Requirements
- R1: After reset the domain is awake, the mode register reads 2'b01, `mode_hib` is 0, `wake_req` is 0 and `conv_early` is 0.
- R2: With the domain awake, a request to any address other than `MODE_ADDR` asserts `per_sel` and `req_ready` in the same cycle, with address, write data and direction copied to the peripheral bus. A read returns `per_rdata` on `rsp_rdata`.
- R3: The mode register sits at `MODE_ADDR` and reads back in bits [1:0] with zeros above. Writing 2'b01 (active) or 2'b10 (hibernate) stores the value. Writing 2'b00 or 2'b11 leaves it unchanged. Mode accesses never assert `per_sel`.
- R4: A request that arrives while the domain sleeps raises `wake_req` from the next cycle on. It keeps `req_ready` and `per_sel` low for as long as `wake_req` is high.
- R5: When `wake_ack` is high at a clock edge while `wake_req` is high, `wake_req` drops after that edge, the domain is awake, and the held request completes as a pass-through in the next cycle.
- R6: Writing 2'b10 sets `mode_hib` and puts the domain to sleep. After a wake-up, `mode_hib` stays 1 until 2'b01 is written.
- R7: If `wake_ack` does not come within `WAKE_TIMEOUT` cycles of `wake_req`, the bridge gives `req_ready` and `rsp_err` for exactly one cycle. `wake_req` falls and the domain stays asleep, so the next request wakes it again.
- R8: For ceil(SETTLE_NS*CLK_MHZ/1000) cycles after the acknowledged wake edge, `conv_start_out` stays low whatever `conv_start_req` does.
- R9: A conversion request refused because the domain sleeps or is settling sets `conv_early`. The flag stays set until reset.
- R10: With the domain awake and settled, `conv_start_out` follows `conv_start_req` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Upstream request valid |
| req_ready | output | 1 | Upstream request accepted / response valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Register address |
| req_wdata | input | DW | Write data |
| rsp_rdata | output | DW | Read data, valid with `req_ready` |
| rsp_err | output | 1 | Error response (wake timeout), valid with `req_ready` |
| per_sel | output | 1 | Peripheral bus select |
| per_write | output | 1 | Peripheral bus direction |
| per_addr | output | AW | Peripheral bus address |
| per_wdata | output | DW | Peripheral bus write data |
| per_rdata | input | DW | Peripheral bus read data (same cycle) |
| wake_req | output | 1 | Wake request to the domain |
| wake_ack | input | 1 | Domain reports wake complete |
| conv_start_req | input | 1 | Conversion start request |
| conv_start_out | output | 1 | Gated conversion start |
| conv_early | output | 1 | Sticky: a start was refused |
| mode_hib | output | 1 | Mode register does not hold the active code |

## Verification
The hardest situations to reach are an acknowledge that lands on the last cycle before the timeout, and a conversion request on the exact cycle the settle window closes. Both depend on where a wake began, and that is set by an earlier mode write and an access that follows it. The stimulus uses a short timeout and a short settle window, sweeps the acknowledge delay across and beyond the timeout, and holds the conversion request high through whole windows. A behavioural model compares every output on every cycle, so each boundary cycle is checked.

// File: rtl/hib_bridge_pkg.sv
package hib_bridge_pkg;
  typedef enum logic [1:0] {
    WS_IDLE = 2'b00,
    WS_WAKE = 2'b01,
    WS_FAIL = 2'b10
  } wake_state_t;

  localparam logic [1:0] MODE_ACTIVE = 2'b01;
  localparam logic [1:0] MODE_HIBER  = 2'b10;
endpackage

// File: rtl/hbr_rst_sync.sv
module hbr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/hbr_wake_ctrl.sv
module hbr_wake_ctrl
  import hib_bridge_pkg::*;
#(
  parameter int TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_pending,
  input  logic sleep_cmd,
  input  logic wake_ack,
  output logic awake,
  output logic waking,
  output logic fail,
  output logic woke,
  output logic pass_ok
);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT - 1);

  wake_state_t st_q, st_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic awake_q, awake_d;
  logic cnt_en;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    awake_d = awake_q;
    cnt_en  = 1'b0;
    unique case (st_q)
      WS_IDLE: begin
        if (!awake_q && acc_pending) begin
          st_d   = WS_WAKE;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end else if (awake_q && sleep_cmd) begin
          awake_d = 1'b0;
        end
      end
      WS_WAKE: begin
        if (wake_ack) begin
          st_d    = WS_IDLE;
          awake_d = 1'b1;
        end else if (cnt_q == LAST) begin
          st_d = WS_FAIL;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      WS_FAIL: st_d = WS_IDLE;
      default: st_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WS_IDLE;
      awake_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      awake_q <= awake_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign awake   = awake_q;
  assign waking  = (st_q == WS_WAKE);
  assign fail    = (st_q == WS_FAIL);
  assign woke    = (st_q == WS_WAKE) && wake_ack;
  assign pass_ok = (st_q == WS_IDLE) && awake_q;
endmodule

// File: rtl/hbr_settle_timer.sv
module hbr_settle_timer #(
  parameter int CYCLES = 11000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic settled
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] START = CW'(CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load) begin
      cnt_d  = START;
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign settled = (cnt_q == '0);
endmodule

// File: rtl/hbr_conv_gate.sv
module hbr_conv_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic allow,
  output logic start_go,
  output logic early
);
  logic early_q, early_set;

  assign start_go  = start_req && allow;
  assign early_set = start_req && !allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         early_q <= 1'b0;
    else if (early_set) early_q <= 1'b1;
  end

  assign early = early_q;
endmodule

// File: rtl/hib_wake_bridge.sv
module hib_wake_bridge
  import hib_bridge_pkg::*;
#(
  parameter int AW           = 8,
  parameter int DW           = 16,
  parameter int MODE_ADDR    = 255,
  parameter int WAKE_TIMEOUT = 64,
  parameter int CLK_MHZ      = 100,
  parameter int SETTLE_NS    = 110000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err,
  output logic          per_sel,
  output logic          per_write,
  output logic [AW-1:0] per_addr,
  output logic [DW-1:0] per_wdata,
  input  logic [DW-1:0] per_rdata,
  output logic          wake_req,
  input  logic          wake_ack,
  input  logic          conv_start_req,
  output logic          conv_start_out,
  output logic          conv_early,
  output logic          mode_hib
);
  localparam int SETTLE_CYC = (SETTLE_NS * CLK_MHZ + 999) / 1000;
  localparam logic [AW-1:0] MODE_A = AW'(MODE_ADDR);

  logic rst_n_i;
  logic awake, waking, fail, woke, pass_ok, settled;
  logic is_mode, mode_we, mode_code_ok, sleep_cmd;
  logic [1:0] mode_q, mode_d;

  hbr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  hbr_wake_ctrl #(.TIMEOUT(WAKE_TIMEOUT)) u_wake (
    .clk(clk), .rst_n(rst_n_i), .acc_pending(req_valid),
    .sleep_cmd(sleep_cmd), .wake_ack(wake_ack), .awake(awake),
    .waking(waking), .fail(fail), .woke(woke), .pass_ok(pass_ok)
  );

  hbr_settle_timer #(.CYCLES(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n_i), .load(woke), .settled(settled)
  );

  hbr_conv_gate u_conv (
    .clk(clk), .rst_n(rst_n_i), .start_req(conv_start_req),
    .allow(awake && settled), .start_go(conv_start_out), .early(conv_early)
  );

  assign is_mode      = (req_addr == MODE_A);
  assign mode_we      = req_valid && pass_ok && req_write && is_mode;
  assign mode_code_ok = (req_wdata[1:0] == MODE_ACTIVE) || (req_wdata[1:0] == MODE_HIBER);
  assign sleep_cmd    = mode_we && (req_wdata[1:0] == MODE_HIBER);

  always_comb begin
    mode_d = mode_q;
    if (mode_we && mode_code_ok) mode_d = req_wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) mode_q <= MODE_ACTIVE;
    else          mode_q <= mode_d;
  end

  assign req_ready = pass_ok || fail;
  assign rsp_err   = fail;
  assign per_sel   = req_valid && pass_ok && !is_mode;
  assign per_write = req_write;
  assign per_addr  = req_addr;
  assign per_wdata = req_wdata;
  assign rsp_rdata = is_mode ? {{(DW-2){1'b0}}, mode_q} : per_rdata;
  assign wake_req  = waking;
  assign mode_hib  = (mode_q != MODE_ACTIVE);
endmodule

// File: rtl/hbr_checker.sv
module hbr_checker (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic per_sel,
  input logic rsp_err,
  input logic wake_req,
  input logic wake_ack,
  input logic conv_start_req,
  input logic conv_start_out,
  input logic conv_early
);
  assert_psel_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    per_sel |-> req_ready);
  assert_wake_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (!req_ready && !per_sel));
  assert_wake_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && wake_ack) |=> !wake_req);
  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |=> !rsp_err);
  assert_settle_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && wake_ack) |=> !conv_start_out);
  assert_early_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_early |=> conv_early);
  assert_conv_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_out |-> (conv_start_req && !wake_req));
endmodule

bind hib_wake_bridge hbr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .per_sel(per_sel),
  .rsp_err(rsp_err), .wake_req(wake_req), .wake_ack(wake_ack),
  .conv_start_req(conv_start_req), .conv_start_out(conv_start_out),
  .conv_early(conv_early)
);

// File: tb/hib_wake_bridge_test.sv
module hib_wake_bridge_test;
  localparam int CLK_P   = 10;
  localparam int AW      = 8;
  localparam int DW      = 16;
  localparam int MADDR   = 255;
  localparam int TO      = 8;
  localparam int SCYC    = 110;   // ceil(110000 ns * 1 MHz / 1000)

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, wake_ack = 0, conv_start_req = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_err, per_sel, per_write, wake_req, conv_start_out, conv_early, mode_hib;
  logic [AW-1:0] per_addr;
  logic [DW-1:0] per_wdata, per_rdata, rsp_rdata;

  int checks = 0, fails = 0, cyc = 0;
  int ack_dly = 0, wcount = 0;
  bit rand_conv = 0;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [DW-1:0] pf(input logic [AW-1:0] a);
    return {a ^ 8'h3C, a};
  endfunction
  assign per_rdata = per_sel ? pf(per_addr) : '0;

  hib_wake_bridge #(.AW(AW), .DW(DW), .MODE_ADDR(MADDR), .WAKE_TIMEOUT(TO),
                    .CLK_MHZ(1), .SETTLE_NS(110000)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .per_sel(per_sel),
    .per_write(per_write), .per_addr(per_addr), .per_wdata(per_wdata),
    .per_rdata(per_rdata), .wake_req(wake_req), .wake_ack(wake_ack),
    .conv_start_req(conv_start_req), .conv_start_out(conv_start_out),
    .conv_early(conv_early), .mode_hib(mode_hib));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference model: 0 idle, 1 waking, 2 error response
  int m_st = 0, m_wc = 0, m_settle = 0;
  bit m_awake = 1, m_early = 0;
  logic [1:0] m_mode = 2'b01;

  function automatic bit m_ready(); return (m_st == 0 && m_awake) || m_st == 2; endfunction
  function automatic bit m_conv(); return conv_start_req && m_awake && m_settle == 0; endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_st = 0; m_wc = 0; m_settle = 0; m_awake = 1; m_early = 0; m_mode = 2'b01;
    end else begin
      if (conv_start_req && !m_conv()) m_early = 1;
      if (m_settle > 0) m_settle--;
      case (m_st)
        0: if (!m_awake && req_valid) begin m_st = 1; m_wc = 0; end
           else if (m_awake && req_valid && req_write && req_addr == AW'(MADDR)) begin
             if (req_wdata[1:0] == 2'b01) m_mode = 2'b01;
             if (req_wdata[1:0] == 2'b10) begin m_mode = 2'b10; m_awake = 0; end
           end
        1: if (wake_ack) begin m_st = 0; m_awake = 1; m_settle = SCYC; end
           else if (m_wc == TO-1) m_st = 2;
           else m_wc++;
        default: m_st = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    #(CLK_P/4);
    if (rst_n && cyc > 3) begin
      chk(req_ready == m_ready(), "R4", req_ready, m_ready());
      chk(wake_req == (m_st == 1), "R4", wake_req, m_st == 1);
      chk(rsp_err == (m_st == 2), "R7", rsp_err, m_st == 2);
      chk(per_sel == (req_valid && m_st == 0 && m_awake && req_addr != AW'(MADDR)),
          "R2", per_sel, 0);
      chk(conv_start_out == m_conv(), "R8", conv_start_out, m_conv());
      chk(conv_early == m_early, "R9", conv_early, m_early);
      chk(mode_hib == (m_mode != 2'b01), "R6", mode_hib, m_mode != 2'b01);
      if (req_valid && m_ready() && m_st != 2 && !req_write)
        chk(rsp_rdata == (req_addr == AW'(MADDR) ? {14'b0, m_mode} : pf(req_addr)),
            "R3", rsp_rdata, 0);
      if (per_sel)
        chk(per_addr == req_addr && per_wdata == req_wdata && per_write == req_write,
            "R2", per_addr, req_addr);
    end
  end

  // wake acknowledge responder and random conversion requests
  always @(negedge clk) begin
    if (wake_req) begin
      wake_ack <= (ack_dly >= 0 && wcount >= ack_dly);
      wcount <= wcount + 1;
    end else begin
      wake_ack <= 1'b0;
      wcount <= 0;
    end
    if (rand_conv) conv_start_req <= ($urandom_range(0, 3) == 0);
  end

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic access(input bit wr, input int a, input int d,
                        output logic [DW-1:0] rd, output bit er, output int lat);
    bit done = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = AW'(a); req_wdata = DW'(d);
    lat = 0;
    while (!done) begin
      #(CLK_P/4);
      if (req_ready) begin done = 1; rd = rsp_rdata; er = rsp_err; end
      @(negedge clk);
      if (!done) lat++;
    end
    req_valid = 0;
  endtask

  initial begin
    logic [DW-1:0] rd; bit er; int lat;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #(CLK_P/4);
    chk(req_ready && !wake_req && !conv_early && !mode_hib, "R1", {req_ready, wake_req, conv_early, mode_hib}, 4'b1000);
    access(0, MADDR, 0, rd, er, lat);
    chk(rd == 16'h0001, "R1", rd, 1);

    access(0, 8'h10, 0, rd, er, lat);
    chk(rd == pf(8'h10) && lat == 0, "R2", rd, pf(8'h10));
    access(1, 8'h20, 16'hBEEF, rd, er, lat);
    chk(lat == 0 && !er, "R2", lat, 0);

    access(1, MADDR, 3, rd, er, lat);
    access(0, MADDR, 0, rd, er, lat);
    chk(rd == 16'h0001, "R3", rd, 1);
    access(1, MADDR, 0, rd, er, lat);
    access(0, MADDR, 0, rd, er, lat);
    chk(rd == 16'h0001, "R3", rd, 1);

    @(negedge clk); conv_start_req = 1;
    #(CLK_P/4); chk(conv_start_out == 1, "R10", conv_start_out, 1);
    @(negedge clk); conv_start_req = 0;

    access(1, MADDR, 2, rd, er, lat);
    #(CLK_P/4); chk(mode_hib == 1, "R6", mode_hib, 1);
    @(negedge clk); conv_start_req = 1;
    #(CLK_P/4); chk(conv_start_out == 0, "R9", conv_start_out, 0);
    @(negedge clk); conv_start_req = 0;
    #(CLK_P/4); chk(conv_early == 1, "R9", conv_early, 1);

    ack_dly = 3;
    access(0, 8'h30, 0, rd, er, lat);
    chk(!er && rd == pf(8'h30), "R5", rd, pf(8'h30));
    chk(lat == 5, "R5", lat, 5);   // request cycle, 4 wake cycles, then pass-through
    chk(mode_hib == 1, "R6", mode_hib, 1);
    conv_start_req = 1;
    begin
      int n = 0;
      while (n < 300) begin
        #(CLK_P/4);
        if (conv_start_out) break;
        @(negedge clk); n++;
      end
      chk(n == SCYC - 1, "R8", n, SCYC - 1);  // one window cycle was used by the completing access
    end
    @(negedge clk); conv_start_req = 0;
    access(1, MADDR, 1, rd, er, lat);
    #(CLK_P/4); chk(mode_hib == 0, "R6", mode_hib, 0);

    access(1, MADDR, 2, rd, er, lat);
    ack_dly = -1;
    access(0, 8'h44, 0, rd, er, lat);
    chk(er == 1 && lat == TO + 1, "R7", lat, TO + 1);
    ack_dly = TO - 1;
    access(0, 8'h45, 0, rd, er, lat);
    chk(er == 0 && rd == pf(8'h45), "R7", er, 0);
    ack_dly = TO;
    access(1, MADDR, 2, rd, er, lat);
    access(0, 8'h46, 0, rd, er, lat);
    chk(er == 1, "R7", er, 1);

    rand_conv = 1;
    for (int i = 0; i < 400; i++) begin
      int a, d;
      ack_dly = ($urandom_range(0, 9) == 0) ? -1 : int'($urandom_range(0, TO + 1));
      a = ($urandom_range(0, 3) == 0) ? MADDR : int'($urandom_range(0, 254));
      d = int'($urandom_range(0, 3));
      access($urandom_range(0, 1), a, d, rd, er, lat);
      repeat ($urandom_range(0, 20)) @(negedge clk);
    end
    rand_conv = 0;
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule